// File: doc/BRIEF.md
# SR-IOV Capability Register File

This block holds the configuration registers of a single-root I/O virtualization extended capability for one physical function. A config-space access port reaches it with a dword index relative to the capability base, four byte enables, write data and a write strobe. Read data is a combinational function of the index and the stored state. A write takes effect at the next clock edge.

Software uses the block to size the virtual functions, program how many are instantiated, choose a system page size, program the VF BAR bases and then enable the functions. Which fields are writable depends on state. The VF count locks while the functions are enabled. The enable bit can only be set if the last programmed count fits within the total. Each VF BAR masks off its low address bits according to its size, which is a parameter. The block drives the enable state, the VF memory-space enable, the ARI hierarchy bit and the number of active VFs to the rest of the function.

Top module: `sriov_cap_regs`

## Requirements
- R1: Dword map, indexed from the capability base:
  - 0: control in bits [15:0], with VF enable at bit 0, VF memory-space enable at bit 3 and ARI hierarchy at bit 4.
  - 1: InitialVFs in [15:0] and TotalVFs in [31:16].
  - 2: NumVFs in [15:0].
  - 3: VF offset in [15:0] and VF stride in [31:16].
  - 4: VF device ID in [31:16].
  - 5: supported page sizes.
  - 6: system page size.
  - 7 to 12: VF BAR0 to BAR5.
  - Bits not listed read zero. Only control bits 0, 3 and 4 accept writes; every other control bit reads zero.
- R2: While VF enable is 1, writes to NumVFs leave it unchanged. Once VF enable reads 0, all 16 bits of NumVFs accept writes.
- R3: A write that touches NumVFs decides whether VF enable may be changed afterwards. VF enable is writable only if that written NumVFs value is at most TotalVFs. The memory-space enable and ARI bits are writable at all times. After reset, VF enable is writable.
- R4: Reset sets the following values:
  - control, VF enable and NumVFs: 0
  - system page size: 0x1
  - supported page sizes: the parameter, 0x553 by default
  - each VF BAR: its type bits, with an upper 64-bit half reading 0
- R5: Only the system page size bits that are set in the supported page sizes accept writes; all others stay 0.
- R6: A 32-bit memory or I/O VF BAR dword accepts writes only on the bits of ~(size-1). Its low type bits always read the configured type (4 bits for memory, 2 for I/O). A BAR with size code 0 is read-only.
- R7: A 64-bit memory BAR (type bits [2:1]=10) uses its own dword and the next one. The 64-bit mask ~(size-1) is split across the two dwords. With the default 16 GiB BAR2, BAR2 keeps only its type 0xC, and BAR3 accepts bits [31:2].
- R8: active_vfs equals NumVFs while VF enable is 1, and is 0 otherwise. vf_enable, vf_mem_enable and ari_hierarchy follow control bits 0, 3 and 4.
- R9: InitialVFs, TotalVFs, VF offset, VF stride, VF device ID and supported page sizes come from parameters and ignore writes.
- R10: Each byte enable gates its own byte lane. A byte lane whose enable is 0 keeps its old value even where the field mask allows writes.
- R11: Accesses at dword index 13 or above change no register and read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Write strobe for the current access |
| cfg_addr | input | ADDR_W | Dword index relative to the capability base |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr |
| vf_enable | output | 1 | VF enable state |
| vf_mem_enable | output | 1 | VF memory-space enable |
| ari_hierarchy | output | 1 | ARI capable hierarchy bit |
| active_vfs | output | 16 | Number of enabled VFs |

## Verification
Every NumVFs value from 0 to 15 is programmed with a TotalVFs of 6, and an enable is attempted for each. This separates counts that are allowed to enable from those that are not, and it checks that a locked count ignores a write. The system page size is swept one bit at a time, which tells supported bits from unsupported ones. Writes of all ones and of all zeros to each VF BAR separate the 32-bit, I/O, 64-bit lower, 64-bit upper and unimplemented masks. Partial byte enables, stray writes outside the map and a reset in the middle of the run show that lanes are honoured, that stray writes do not alias onto registers, and that the reset values come back.

// File: rtl/sriov_cap_pkg.sv
package sriov_cap_pkg;

  localparam int unsigned CAP_DW   = 13;
  localparam int unsigned NUM_BARS = 6;

  localparam int unsigned DW_CTRL  = 0;
  localparam int unsigned DW_VFCNT = 1;
  localparam int unsigned DW_NUMVF = 2;
  localparam int unsigned DW_RID   = 3;
  localparam int unsigned DW_DEVID = 4;
  localparam int unsigned DW_SUPPG = 5;
  localparam int unsigned DW_SYSPG = 6;
  localparam int unsigned DW_BAR0  = 7;

  localparam int unsigned CTL_VFE = 0;
  localparam int unsigned CTL_MSE = 3;
  localparam int unsigned CTL_ARI = 4;

  // Expand four byte enables into a 32-bit lane mask.
  function automatic logic [31:0] lane_expand(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  // Writable address bits of a BAR given log2 of its size; 0 means none.
  function automatic logic [63:0] size_mask(input logic [5:0] lg2);
    if (lg2 == 6'd0) return 64'd0;
    return ~((64'd1 << lg2) - 64'd1);
  endfunction

  function automatic logic is_mem64(input logic [3:0] typ);
    return (typ[0] == 1'b0) && (typ[2:1] == 2'b10);
  endfunction

  // Constant type bits: two for I/O, four for memory.
  function automatic logic [31:0] type_bits(input logic [3:0] typ);
    return typ[0] ? 32'h3 : 32'hF;
  endfunction

  // True when BAR idx is the upper half of a 64-bit pair.
  function automatic logic is_upper(input logic [NUM_BARS-1:0][3:0] types,
                                    input int unsigned idx);
    logic up;
    up = 1'b0;
    for (int unsigned k = 1; k <= idx; k++) up = !up && is_mem64(types[k-1]);
    return up;
  endfunction

endpackage

// File: rtl/sriov_cap_ctl.sv
module sriov_cap_ctl
  import sriov_cap_pkg::*;
#(
  parameter int unsigned TOTAL_VFS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_numvf,
  input  logic [31:0] lane_mask,
  input  logic [31:0] wdata,
  output logic        vfe_q,
  output logic        mse_q,
  output logic        ari_q,
  output logic [15:0] num_q
);

  localparam logic [15:0] TOTAL16 = 16'(TOTAL_VFS);

  logic        vfe_ok_q, vfe_ok_n;
  logic        vfe_n, mse_n, ari_n;
  logic [15:0] num_n;
  logic [15:0] ctl_old, ctl_wm, ctl_new;
  logic [15:0] num_wm, num_new;
  logic        ce;

  always_comb begin
    ctl_old          = '0;
    ctl_old[CTL_VFE] = vfe_q;
    ctl_old[CTL_MSE] = mse_q;
    ctl_old[CTL_ARI] = ari_q;
    ctl_wm           = '0;
    ctl_wm[CTL_MSE]  = 1'b1;
    ctl_wm[CTL_ARI]  = 1'b1;
    ctl_wm[CTL_VFE]  = vfe_ok_q;
    ctl_wm           = ctl_wm & lane_mask[15:0];
    ctl_new          = (ctl_old & ~ctl_wm) | (wdata[15:0] & ctl_wm);

    num_wm  = (vfe_q ? 16'h0000 : 16'hFFFF) & lane_mask[15:0];
    num_new = (num_q & ~num_wm) | (wdata[15:0] & num_wm);

    vfe_n = wr_ctrl ? ctl_new[CTL_VFE] : vfe_q;
    mse_n = wr_ctrl ? ctl_new[CTL_MSE] : mse_q;
    ari_n = wr_ctrl ? ctl_new[CTL_ARI] : ari_q;
    num_n = wr_numvf ? num_new : num_q;

    if (wr_numvf && (|lane_mask[15:0])) vfe_ok_n = (num_new <= TOTAL16);
    else                                vfe_ok_n = vfe_ok_q;

    ce = wr_ctrl | wr_numvf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vfe_q    <= 1'b0;
      mse_q    <= 1'b0;
      ari_q    <= 1'b0;
      num_q    <= '0;
      vfe_ok_q <= 1'b1;
    end else if (ce) begin
      vfe_q    <= vfe_n;
      mse_q    <= mse_n;
      ari_q    <= ari_n;
      num_q    <= num_n;
      vfe_ok_q <= vfe_ok_n;
    end
  end

endmodule

// File: rtl/sriov_cap_field.sv
module sriov_cap_field #(
  parameter logic [31:0] RST_VAL = 32'h0,
  parameter logic [31:0] WMASK   = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] lane_mask,
  input  logic [31:0] wdata,
  output logic [31:0] q
);

  logic [31:0] eff_mask;
  logic [31:0] d;

  always_comb begin
    eff_mask = WMASK & lane_mask;
    d        = (q & ~eff_mask) | (wdata & eff_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (wr) q <= d;
  end

endmodule

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs
  import sriov_cap_pkg::*;
#(
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned INITIAL_VFS  = 4,
  parameter int unsigned TOTAL_VFS    = 6,
  parameter logic [15:0] VF_OFFSET    = 16'h0001,
  parameter logic [15:0] VF_STRIDE    = 16'h0001,
  parameter logic [15:0] VF_DEVICE_ID = 16'hA5C3,
  parameter logic [31:0] SUP_PGSZ     = 32'h0000_0553,
  parameter logic [NUM_BARS-1:0][3:0] VF_BAR_TYPE =
    {4'h0, 4'h0, 4'h0, 4'hC, 4'h1, 4'h0},
  parameter logic [NUM_BARS-1:0][5:0] VF_BAR_LG2 =
    {6'd0, 6'd16, 6'd34, 6'd34, 6'd8, 6'd12}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              vf_enable,
  output logic              vf_mem_enable,
  output logic              ari_hierarchy,
  output logic [15:0]       active_vfs
);

  localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(CAP_DW);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(DW_CTRL);
  localparam logic [ADDR_W-1:0] A_VFCNT = ADDR_W'(DW_VFCNT);
  localparam logic [ADDR_W-1:0] A_NUMVF = ADDR_W'(DW_NUMVF);
  localparam logic [ADDR_W-1:0] A_RID   = ADDR_W'(DW_RID);
  localparam logic [ADDR_W-1:0] A_DEVID = ADDR_W'(DW_DEVID);
  localparam logic [ADDR_W-1:0] A_SUPPG = ADDR_W'(DW_SUPPG);
  localparam logic [ADDR_W-1:0] A_SYSPG = ADDR_W'(DW_SYSPG);

  // Reset synchronizer: asynchronous assert, synchronous release.
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic        rst_int_n;
  logic        in_range;
  logic        wr_hit;
  logic [31:0] lane_mask;
  logic        vfe_q, mse_q, ari_q;
  logic [15:0] num_vfs_q;
  logic [31:0] sys_pg_q;
  logic [NUM_BARS-1:0][31:0] bar_q;

  always_comb begin
    rst_int_n = rst_s2_q;
    in_range  = (cfg_addr < A_LIMIT);
    wr_hit    = cfg_wr_en && in_range;
    lane_mask = lane_expand(cfg_be);
  end

  sriov_cap_ctl #(
    .TOTAL_VFS (TOTAL_VFS)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_ctrl   (wr_hit && (cfg_addr == A_CTRL)),
    .wr_numvf  (wr_hit && (cfg_addr == A_NUMVF)),
    .lane_mask (lane_mask),
    .wdata     (cfg_wdata),
    .vfe_q     (vfe_q),
    .mse_q     (mse_q),
    .ari_q     (ari_q),
    .num_q     (num_vfs_q)
  );

  sriov_cap_field #(
    .RST_VAL (32'h0000_0001),
    .WMASK   (SUP_PGSZ)
  ) u_syspg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr        (wr_hit && (cfg_addr == A_SYSPG)),
    .lane_mask (lane_mask),
    .wdata     (cfg_wdata),
    .q         (sys_pg_q)
  );

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    localparam logic        UPPER = is_upper(VF_BAR_TYPE, i);
    localparam logic [63:0] M_LO  = size_mask(VF_BAR_LG2[i]);
    localparam logic [63:0] M_HI  = (i > 0) ? size_mask(VF_BAR_LG2[(i > 0) ? i-1 : 0]) : 64'd0;
    localparam logic [31:0] WM    = UPPER ? M_HI[63:32]
                                          : (M_LO[31:0] & ~type_bits(VF_BAR_TYPE[i]));
    localparam logic [31:0] RV    = UPPER ? 32'h0 : {28'h0, VF_BAR_TYPE[i]};
    localparam logic [ADDR_W-1:0] A_BAR = ADDR_W'(DW_BAR0 + i);

    sriov_cap_field #(
      .RST_VAL (RV),
      .WMASK   (WM)
    ) u_bar (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr        (wr_hit && (cfg_addr == A_BAR)),
      .lane_mask (lane_mask),
      .wdata     (cfg_wdata),
      .q         (bar_q[i])
    );
  end

  // Read path
  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_CTRL: begin
        cfg_rdata[CTL_VFE] = vfe_q;
        cfg_rdata[CTL_MSE] = mse_q;
        cfg_rdata[CTL_ARI] = ari_q;
      end
      A_VFCNT: cfg_rdata = {16'(TOTAL_VFS), 16'(INITIAL_VFS)};
      A_NUMVF: cfg_rdata = {16'h0, num_vfs_q};
      A_RID:   cfg_rdata = {VF_STRIDE, VF_OFFSET};
      A_DEVID: cfg_rdata = {VF_DEVICE_ID, 16'h0};
      A_SUPPG: cfg_rdata = SUP_PGSZ;
      A_SYSPG: cfg_rdata = sys_pg_q;
      default: begin
        for (int i = 0; i < NUM_BARS; i++) begin
          if (cfg_addr == ADDR_W'(DW_BAR0 + i)) cfg_rdata = bar_q[i];
        end
      end
    endcase
  end

  always_comb begin
    vf_enable     = vfe_q;
    vf_mem_enable = mse_q;
    ari_hierarchy = ari_q;
    active_vfs    = vfe_q ? num_vfs_q : 16'h0;
  end

endmodule

// File: rtl/sriov_cap_chk.sv
module sriov_cap_chk #(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned TOTAL_VFS = 6,
  parameter logic [31:0] SUP_PGSZ  = 32'h553,
  parameter logic [3:0]  BAR0_TYPE = 4'h0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic              vf_enable,
  input logic [15:0]       num_vfs,
  input logic [31:0]       sys_pg
);

  AST_NUMVF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vf_enable) |-> $stable(num_vfs)); // R2

  AST_VFE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vf_enable) |-> (num_vfs <= 16'(TOTAL_VFS))); // R3

  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == ADDR_W'(0)) |-> ((cfg_rdata & ~32'h19) == 32'h0)); // R1

  AST_SYSPG_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_pg & ~SUP_PGSZ) == 32'h0); // R5

  AST_BAR0_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == ADDR_W'(7)) |-> (cfg_rdata[3:0] == BAR0_TYPE)); // R6

  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr >= ADDR_W'(13)) |-> (cfg_rdata == 32'h0)); // R11

endmodule

bind sriov_cap_regs sriov_cap_chk #(
  .ADDR_W    (ADDR_W),
  .TOTAL_VFS (TOTAL_VFS),
  .SUP_PGSZ  (SUP_PGSZ),
  .BAR0_TYPE (VF_BAR_TYPE[0])
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .vf_enable (vf_enable),
  .num_vfs   (num_vfs_q),
  .sys_pg    (sys_pg_q)
);

// File: tb/sriov_cap_regs_tb.sv
`timescale 1ns/1ps
module sriov_cap_regs_tb;

  localparam int unsigned TOTAL = 6;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [4:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        vf_enable, vf_mem_enable, ari_hierarchy;
  logic [15:0] active_vfs;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  sriov_cap_regs u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_addr      (cfg_addr),
    .cfg_be        (cfg_be),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .vf_enable     (vf_enable),
    .vf_mem_enable (vf_mem_enable),
    .ari_hierarchy (ari_hierarchy),
    .active_vfs    (active_vfs)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_addr  = 5'(a);
    cfg_be    = be;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    cfg_addr = 5'(a);
    #1;
    d = cfg_rdata;
  endtask

  function automatic logic [63:0] smask(input int lg2);
    if (lg2 == 0) return 64'd0;
    return ~((64'd1 << lg2) - 64'd1);
  endfunction

  // Expected BAR values after all-ones and after all-zeros writes
  logic [31:0] bar_rst  [6];
  logic [31:0] bar_ones [6];

  task automatic reset_checks(input string when);
    logic [31:0] v;
    rd(0, v);  chk({"R4 ctrl ", when}, v, 32'h0);
    rd(2, v);  chk({"R4 numvfs ", when}, v, 32'h0);
    rd(5, v);  chk({"R4 suppg ", when}, v, 32'h553);
    rd(6, v);  chk({"R4 syspg ", when}, v, 32'h1);
    for (int i = 0; i < 6; i++) begin
      rd(7 + i, v); chk($sformatf("R4 bar%0d %s", i, when), v, bar_rst[i]);
    end
    chk({"R8 vfe ", when}, {31'h0, vf_enable}, 32'h0);
    chk({"R8 active ", when}, {16'h0, active_vfs}, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    bar_rst[0] = 32'h0; bar_rst[1] = 32'h1; bar_rst[2] = 32'hC;
    bar_rst[3] = 32'h0; bar_rst[4] = 32'h0; bar_rst[5] = 32'h0;
    bar_ones[0] = smask(12)[31:0];
    bar_ones[1] = (smask(8)[31:0] & ~32'h3) | 32'h1;
    bar_ones[2] = (smask(34)[31:0] & ~32'hF) | 32'hC;
    bar_ones[3] = smask(34)[63:32];
    bar_ones[4] = smask(16)[31:0];
    bar_ones[5] = 32'h0;

    cfg_wr_en = 0; cfg_addr = 0; cfg_be = 0; cfg_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    reset_checks("initial");

    // R9 / R1: read-only parameter fields
    for (int a = 1; a <= 5; a++) if (a != 2) wr(a, 4'hF, 32'hFFFF_FFFF);
    rd(1, v); chk("R9 counts", v, {16'(TOTAL), 16'd4});
    rd(3, v); chk("R9 offset/stride", v, 32'h0001_0001);
    rd(4, v); chk("R9 devid", v, 32'hA5C3_0000);
    rd(5, v); chk("R9 suppg", v, 32'h553);

    // R1: only bits 0, 3, 4 of control are writable
    wr(0, 4'hF, 32'hFFFF_FFFF);
    rd(0, v); chk("R1 ctrl ones", v, 32'h19);
    chk("R8 mse out", {31'h0, vf_mem_enable}, 32'h1);
    chk("R8 ari out", {31'h0, ari_hierarchy}, 32'h1);
    chk("R8 active numvf0", {16'h0, active_vfs}, 32'h0);
    wr(0, 4'hF, 32'h0);
    rd(0, v); chk("R1 ctrl zero", v, 32'h0);

    // R2 / R3 / R8 sweep of NumVFs
    for (int n = 0; n < 16; n++) begin
      logic ok;
      ok = (n <= TOTAL);
      wr(0, 4'hF, 32'h0);
      wr(2, 4'h3, 32'(n));
      rd(2, v); chk($sformatf("R2 numvf write n=%0d", n), v, 32'(n));
      wr(0, 4'h1, 32'h1);
      chk($sformatf("R3 vfe n=%0d", n), {31'h0, vf_enable}, {31'h0, ok});
      chk($sformatf("R8 active n=%0d", n), {16'h0, active_vfs}, ok ? 32'(n) : 32'h0);
      wr(2, 4'h3, 32'(n + 1));
      rd(2, v); chk($sformatf("R2 locked n=%0d", n), v, ok ? 32'(n) : 32'(n + 1));
      // R3: MSE and ARI writable regardless
      wr(0, 4'h1, 32'h18 | {31'h0, ok});
      rd(0, v); chk($sformatf("R3 mse/ari n=%0d", n), v, 32'h18 | {31'h0, ok});
    end
    wr(0, 4'hF, 32'h0);
    wr(2, 4'h3, 32'h1234);
    rd(2, v); chk("R2 unlocked after clear", v, 32'h1234);

    // R10: byte lanes
    wr(2, 4'h3, 32'h0012);
    wr(2, 4'h2, 32'hABCD);
    rd(2, v); chk("R10 numvf upper lane", v, 32'hAB12);
    wr(0, 4'hE, 32'h1F);
    rd(0, v); chk("R10 ctrl lane0 off", v, 32'h0);
    wr(6, 4'h2, 32'hFFFF_FFFF);
    rd(6, v); chk("R10 syspg lane1", v, 32'h0000_0501);

    // R5: one-hot page size sweep
    for (int b = 0; b < 32; b++) begin
      wr(6, 4'hF, 32'h1 << b);
      rd(6, v); chk($sformatf("R5 syspg bit%0d", b), v, (32'h1 << b) & 32'h553);
    end
    wr(6, 4'hF, 32'hFFFF_FFFF);
    rd(6, v); chk("R5 syspg ones", v, 32'h553);

    // R6 / R7: BAR masks
    for (int i = 0; i < 6; i++) begin
      wr(7 + i, 4'hF, 32'hFFFF_FFFF);
      rd(7 + i, v); chk($sformatf("R6 R7 bar%0d ones", i), v, bar_ones[i]);
      wr(7 + i, 4'hF, 32'h0);
      rd(7 + i, v); chk($sformatf("R6 R7 bar%0d zeros", i), v, bar_rst[i]);
    end
    wr(7, 4'h1, 32'hFFFF_FFFF);
    rd(7, v); chk("R10 bar0 lane0 only", v, 32'h0);
    wr(7, 4'h2, 32'hFFFF_FFFF);
    rd(7, v); chk("R10 bar0 lane1 only", v, 32'h0000_F000);

    // R11: outside the capability
    wr(0, 4'hF, 32'h0);
    wr(2, 4'h3, 32'h0003);
    for (int a = 13; a < 32; a++) begin
      wr(a, 4'hF, 32'hFFFF_FFFF);
      rd(a, v); chk($sformatf("R11 read a=%0d", a), v, 32'h0);
    end
    rd(0, v); chk("R11 ctrl untouched", v, 32'h0);
    rd(2, v); chk("R11 numvf untouched", v, 32'h3);
    rd(6, v); chk("R11 syspg untouched", v, 32'h553);

    // R4: reset mid-run, after leaving VF enable locked out
    wr(2, 4'h3, 32'h9);
    wr(0, 4'hF, 32'h19);
    wr(7, 4'hF, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    reset_checks("midrun");
    wr(0, 4'h1, 32'h1);
    chk("R3 vfe writable after reset", {31'h0, vf_enable}, 32'h1);
    chk("R8 active after reset", {16'h0, active_vfs}, 32'h0);

    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule